// File: doc/BRIEF.md
# Parallel Flash Configuration Loader

The loader is the bus master that fetches a configuration image from a byte-wide parallel NOR flash once the chip leaves reset. It waits for the initialization signal to rise, and on that edge it latches a direction bit. It then drives a 24-bit flash address that starts either at zero and counts upward, or at the top of the address space and counts downward. After a fixed access latency it captures one data byte per address and offers the byte on a valid/ready stream.

While the load runs, the flash control strobes are held at fixed levels: chip and output enable low, write enable high, and byte-wide mode selected. Backpressure from the stream consumer stalls the address counter. After the last byte has been accepted, the loader stops driving the address and strobe pins, drops their drive enables so user logic can take them over, and raises a sticky done flag. The load is aborted if either enable input goes high.

Top module: `flash_cfg_loader`

## Requirements
- R1: With the latched direction bit at 0, the first address is 0x000000 and each accepted byte advances the address by +1.
- R2: With the latched direction bit at 1, the first address is 0xFFFFFF and each accepted byte moves the address by -1.
- R3: A load starts only on a low-to-high transition of init_i while cs_ni and wr_ni are both low. mode_i is sampled only at that transition, and later changes of mode_i have no effect on the running load.
- R4: While the drive enables are high, flash_ce_no=0, flash_oe_no=0, flash_we_no=1 and flash_byte_no=0. While they are low, all four strobes read 1 and flash_addr_o reads 0.
- R5: byte_valid_o rises ACC_LAT clock cycles after the address changes, and byte_o then equals flash_data_i as sampled at that point for the current address.
- R6: While byte_valid_o is high and byte_ready_i is low, byte_valid_o, byte_o and flash_addr_o hold steady.
- R7: Exactly LOAD_LEN bytes are delivered. done_o stays low until the last byte is accepted and is high on the next cycle. From then on done_o stays high and both drive enables stay low.
- R8: If cs_ni or wr_ni is high during a load, then on the next cycle the drive enables and byte_valid_o are low and done_o stays low. A new load needs a fresh init_i rise and restarts from the start address.
- R9: Asserting rst_ni low returns the loader to idle at once. Idle means valid low, done low and drive enables low, and the loader then waits for an init_i rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Initialization done; its rising edge starts a load |
| mode_i | input | 1 | Direction select, 0 up from zero, 1 down from top |
| cs_ni | input | 1 | Chip select, active low, must stay low while loading |
| wr_ni | input | 1 | Write select, active low, must stay low while loading |
| flash_data_i | input | DATA_W | Flash data bus |
| flash_addr_o | output | ADDR_W | Flash address bus |
| flash_ce_no | output | 1 | Flash chip enable, active low |
| flash_oe_no | output | 1 | Flash output enable, active low |
| flash_we_no | output | 1 | Flash write enable, active low |
| flash_byte_no | output | 1 | Flash byte-mode select, low selects x8 |
| addr_drive_o | output | 1 | Drive enable for the address pin group |
| ctrl_drive_o | output | 1 | Drive enable for the strobe pin group |
| byte_o | output | DATA_W | Captured configuration byte |
| byte_valid_o | output | 1 | byte_o is valid |
| byte_ready_i | input | 1 | Consumer accepts byte_o |
| done_o | output | 1 | Load completed, sticky until reset |

## Verification
On every cycle, the assertions check the strobe levels during a load, the +1 or -1 address step after each accepted byte in the latched direction, stability under backpressure, release within one cycle of an abort, and that done is sticky with the drive enables released. Only the bench scenarios can show the start addresses, the exact access latency before each valid, that mode changes mid-load are ignored, the exact byte count with done on the following cycle, and that no load starts without a fresh init rise.

// File: rtl/flash_cfg_pkg.sv
package flash_cfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PRESENT,
    ST_DONE
  } ld_state_e;
endpackage

// File: rtl/cfg_ld_ctrl.sv
module cfg_ld_ctrl
  import flash_cfg_pkg::*;
#(
  parameter int unsigned LOAD_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic mode_i,
  input  logic en_i,
  input  logic cap_i,
  input  logic hs_i,
  output logic start_o,
  output logic step_o,
  output logic dir_o,
  output logic fetch_o,
  output logic run_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CNT_W = $clog2(LOAD_LEN + 1);

  ld_state_e        state_q;
  logic             init_q;
  logic             dir_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  logic             last;

  assign rise    = init_i & ~init_q;
  assign last    = (cnt_q == CNT_W'(LOAD_LEN - 1));
  assign start_o = (state_q == ST_IDLE) && rise && en_i;
  assign busy_o  = (state_q == ST_FETCH) || (state_q == ST_PRESENT);
  assign run_o   = busy_o && en_i;
  assign fetch_o = (state_q == ST_FETCH) && en_i;
  assign step_o  = (state_q == ST_PRESENT) && en_i && hs_i && !last;
  assign dir_o   = dir_q;
  assign done_o  = (state_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      init_q  <= 1'b0;
      dir_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      init_q <= init_i;
      unique case (state_q)
        ST_IDLE: begin
          if (start_o) begin
            dir_q   <= mode_i;
            cnt_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (!en_i)      state_q <= ST_IDLE;
          else if (cap_i) state_q <= ST_PRESENT;
        end
        ST_PRESENT: begin
          if (!en_i) state_q <= ST_IDLE;
          else if (hs_i) begin
            if (last) state_q <= ST_DONE;
            else begin
              cnt_q   <= cnt_q + 1'b1;
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_dir_i,
  input  logic              step_i,
  input  logic              dir_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= load_dir_i ? '1 : '0;
    else if (step_i) addr_q <= dir_i ? addr_q - 1'b1 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/cfg_byte_fetch.sv
module cfg_byte_fetch #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ACC_LAT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_i,
  input  logic              run_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              cap_o,
  output logic              hs_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              valid_o
);
  localparam int unsigned LAT_W = $clog2(ACC_LAT + 1);

  logic [LAT_W-1:0]  lat_q;
  logic [DATA_W-1:0] byte_q;
  logic              valid_q;

  // access timer restarts whenever the fetch phase is left
  assign cap_o = fetch_i && (lat_q == LAT_W'(ACC_LAT - 1));
  assign hs_o  = valid_q && ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      lat_q <= fetch_i ? lat_q + 1'b1 : '0;
      if (cap_o) byte_q <= data_i;
      if (!run_i)     valid_q <= 1'b0;
      else if (cap_o) valid_q <= 1'b1;
      else if (hs_o)  valid_q <= 1'b0;
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/flash_cfg_loader.sv
module flash_cfg_loader #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned LOAD_LEN = 16,
  parameter int unsigned ACC_LAT  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              mode_i,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] flash_data_i,
  output logic [ADDR_W-1:0] flash_addr_o,
  output logic              flash_ce_no,
  output logic              flash_oe_no,
  output logic              flash_we_no,
  output logic              flash_byte_no,
  output logic              addr_drive_o,
  output logic              ctrl_drive_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic              done_o
);
  logic              en;
  logic              start, step, dir_q, fetch, run, busy, cap, hs;
  logic [ADDR_W-1:0] addr;

  assign en = ~cs_ni & ~wr_ni;

  cfg_ld_ctrl #(.LOAD_LEN(LOAD_LEN)) i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .init_i  (init_i),
    .mode_i  (mode_i),
    .en_i    (en),
    .cap_i   (cap),
    .hs_i    (hs),
    .start_o (start),
    .step_o  (step),
    .dir_o   (dir_q),
    .fetch_o (fetch),
    .run_o   (run),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  cfg_addr_seq #(.ADDR_W(ADDR_W)) i_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_dir_i (mode_i),
    .step_i     (step),
    .dir_i      (dir_q),
    .addr_o     (addr)
  );

  cfg_byte_fetch #(.DATA_W(DATA_W), .ACC_LAT(ACC_LAT)) i_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fetch_i (fetch),
    .run_i   (run),
    .ready_i (byte_ready_i),
    .data_i  (flash_data_i),
    .cap_o   (cap),
    .hs_o    (hs),
    .byte_o  (byte_o),
    .valid_o (byte_valid_o)
  );

  // released pins read back as inactive
  assign flash_addr_o  = busy ? addr : '0;
  assign flash_ce_no   = ~busy;
  assign flash_oe_no   = ~busy;
  assign flash_we_no   = 1'b1;
  assign flash_byte_no = ~busy;
  assign addr_drive_o  = busy;
  assign ctrl_drive_o  = busy;
endmodule

// File: rtl/flash_cfg_loader_chk.sv
module flash_cfg_loader_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              wr_ni,
  input logic [ADDR_W-1:0] flash_addr_o,
  input logic              flash_ce_no,
  input logic              flash_oe_no,
  input logic              flash_we_no,
  input logic              flash_byte_no,
  input logic              addr_drive_o,
  input logic              ctrl_drive_o,
  input logic [DATA_W-1:0] byte_o,
  input logic              byte_valid_o,
  input logic              byte_ready_i,
  input logic              done_o,
  input logic              dir_i
);
  logic hs_ok;
  assign hs_ok = byte_valid_o && byte_ready_i && !cs_ni && !wr_ni;

  a_r4_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_drive_o |-> (!flash_ce_no && !flash_oe_no && flash_we_no && !flash_byte_no));

  a_r1_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ok && !dir_i) |=> (!addr_drive_o || flash_addr_o == ADDR_W'($past(flash_addr_o) + 1'b1)));

  a_r2_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs_ok && dir_i) |=> (!addr_drive_o || flash_addr_o == ADDR_W'($past(flash_addr_o) - 1'b1)));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o && !byte_ready_i && !cs_ni && !wr_ni)
      |=> (byte_valid_o && $stable(byte_o) && $stable(flash_addr_o)));

  a_r8_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_drive_o && (cs_ni || wr_ni)) |=> (!addr_drive_o && !byte_valid_o && !done_o));

  a_r7_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r7_done_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!addr_drive_o && !ctrl_drive_o && !byte_valid_o));
endmodule

bind flash_cfg_loader flash_cfg_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_ni         (cs_ni),
  .wr_ni         (wr_ni),
  .flash_addr_o  (flash_addr_o),
  .flash_ce_no   (flash_ce_no),
  .flash_oe_no   (flash_oe_no),
  .flash_we_no   (flash_we_no),
  .flash_byte_no (flash_byte_no),
  .addr_drive_o  (addr_drive_o),
  .ctrl_drive_o  (ctrl_drive_o),
  .byte_o        (byte_o),
  .byte_valid_o  (byte_valid_o),
  .byte_ready_i  (byte_ready_i),
  .done_o        (done_o),
  .dir_i         (dir_q)
);

// File: tb/test_flash_cfg_loader.sv
`timescale 1ns/1ps
module test_flash_cfg_loader;
  localparam int LEN = 6;
  localparam int LAT = 3;
  // vector bits: [4] direction, [3] flip mode after first byte, [2:0] stall cycles
  localparam logic [4:0] VEC [4] = '{5'b00000, 5'b10010, 5'b01011, 5'b11001};

  logic        clk = 0, rst_ni = 0;
  logic        init_i = 0, mode_i = 0, cs_ni = 0, wr_ni = 0, ready = 0;
  logic [7:0]  fdata, byte_o;
  logic [23:0] faddr;
  logic        ce_n, oe_n, we_n, bm_n, adrv, cdrv, valid, done;
  int          total = 0, bad = 0;

  always #5 clk = ~clk;

  assign fdata = faddr[7:0] ^ faddr[23:16] ^ 8'h5A;

  flash_cfg_loader #(.LOAD_LEN(LEN), .ACC_LAT(LAT)) i_flash_cfg_loader (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .mode_i(mode_i),
    .cs_ni(cs_ni), .wr_ni(wr_ni), .flash_data_i(fdata), .flash_addr_o(faddr),
    .flash_ce_no(ce_n), .flash_oe_no(oe_n), .flash_we_no(we_n), .flash_byte_no(bm_n),
    .addr_drive_o(adrv), .ctrl_drive_o(cdrv), .byte_o(byte_o),
    .byte_valid_o(valid), .byte_ready_i(ready), .done_o(done));

  function automatic logic [7:0] exp_byte(input logic [23:0] a);
    return a[7:0] ^ a[23:16] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " drive"}, {30'd0, adrv, cdrv}, 32'd0);
    chk({req, " strobes"}, {28'd0, ce_n, oe_n, we_n, bm_n}, 32'hF);
    chk({req, " addr"}, {8'd0, faddr}, 32'd0);
    chk({req, " valid"}, {31'd0, valid}, 32'd0);
  endtask

  task automatic do_reset();
    init_i = 0; ready = 0; cs_ni = 0; wr_ni = 0;
    rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  // returns count of negedges with valid low
  task automatic wait_valid(output int lowc);
    lowc = 0;
    while (!valid && lowc < 50) begin
      lowc++;
      @(negedge clk);
    end
  endtask

  task automatic run_load(input logic dir, input logic flip, input int stall);
    logic [23:0] ea;
    int lowc;
    mode_i = dir;
    init_i = 1;
    @(negedge clk);
    ea = dir ? 24'hFFFFFF : 24'h0;
    for (int b = 0; b < LEN; b++) begin
      wait_valid(lowc);
      chk("R5 latency", lowc, LAT);
      chk(dir ? "R2 addr" : "R1 addr", {8'd0, faddr}, {8'd0, ea});
      chk("R5 data", {24'd0, byte_o}, {24'd0, exp_byte(ea)});
      chk("R4 strobes", {26'd0, ce_n, oe_n, we_n, bm_n, adrv, cdrv}, 32'b0010_11);
      if (flip && b == 0) mode_i = ~dir;
      repeat (stall) @(negedge clk);
      if (stall > 0) begin
        chk("R6 valid hold", {31'd0, valid}, 32'd1);
        chk("R6 addr hold", {8'd0, faddr}, {8'd0, ea});
        chk("R6 data hold", {24'd0, byte_o}, {24'd0, exp_byte(ea)});
      end
      ready = 1;
      @(negedge clk);
      ready = 0;
      if (b < LEN - 1) chk("R7 done early", {31'd0, done}, 32'd0);
      ea = dir ? ea - 24'd1 : ea + 24'd1;
    end
    chk("R7 done", {31'd0, done}, 32'd1);
    chk_idle("R7 released");
    repeat (3) @(negedge clk);
    chk("R7 done sticky", {31'd0, done}, 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lowc;
    // R9 reset state, and R3: no load without init rise
    do_reset();
    chk_idle("R9 reset");
    chk("R9 done", {31'd0, done}, 32'd0);
    repeat (5) @(negedge clk);
    chk_idle("R3 no init");

    for (int v = 0; v < 4; v++) begin
      do_reset();
      run_load(VEC[v][4], VEC[v][3], int'(VEC[v][2:0]));
    end

    // R8 abort by cs_ni while a byte is pending
    do_reset();
    mode_i = 0; init_i = 1;
    @(negedge clk);
    wait_valid(lowc);
    ready = 1; @(negedge clk); ready = 0;
    wait_valid(lowc);
    chk("R8 second addr", {8'd0, faddr}, 32'd1);
    cs_ni = 1;
    @(negedge clk);
    chk_idle("R8 cs abort");
    chk("R8 done", {31'd0, done}, 32'd0);
    cs_ni = 0;
    repeat (8) @(negedge clk);
    chk_idle("R8 no restart");
    // R8 restart on new init rise, direction resampled (R3)
    init_i = 0; mode_i = 1;
    @(negedge clk);
    init_i = 1;
    @(negedge clk);
    wait_valid(lowc);
    chk("R8 restart addr", {8'd0, faddr}, 32'hFFFFFF);
    // abort by wr_ni during the fetch phase
    ready = 1; @(negedge clk); ready = 0;
    chk("R8 fetch drive", {31'd0, adrv}, 32'd1);
    wr_ni = 1;
    @(negedge clk);
    chk_idle("R8 wr abort");
    wr_ni = 0;

    // R3 start blocked while cs_ni high at the init rise
    init_i = 0; cs_ni = 1;
    @(negedge clk);
    init_i = 1;
    @(negedge clk);
    cs_ni = 0;
    repeat (6) @(negedge clk);
    chk_idle("R3 blocked start");

    // R9 reset mid-load
    do_reset();
    mode_i = 0; init_i = 1;
    @(negedge clk);
    wait_valid(lowc);
    rst_ni = 0;
    #1;
    chk_idle("R9 mid reset");
    chk("R9 mid done", {31'd0, done}, 32'd0);
    init_i = 0;
    @(negedge clk);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    chk_idle("R9 idle after");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule